// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block chooses the power mode of a small processor subsystem and drives the controls that go with each mode. In run mode the core clock is enabled. The core asks to sleep with a one-cycle WFI or WFE request pulse. Together with a deep-sleep flag and a low-power enable bit, that request selects one of two low-power modes. Sleep mode gates only the core clock. Wait mode also freezes the I/O pin configuration, holds the main clock select, and moves the flash into a power state that a two-bit field picks.

Wait mode ends on any enabled wake source: sixteen pins, a tamper event, an RTC alarm or an RTT alarm. Each source has its own enable, and a sticky status vector records which source caused the wake-up. Sleep mode ends on an interrupt if it was entered with WFI, or on an event if it was entered with WFE. When sleep-on-exit is set, the block falls straight back into sleep as soon as an exception handler returns to thread mode.

After a wake from wait, the flash stays in its low-power state and a pending flag stays high. Both hold until software pulses the restore input.

Top module: `pwr_mode_seq`

## Requirements
- R1: In run mode, a `req_wfe` pulse with `cfg_lpm`=1 and `cfg_deep_sleep`=0 makes `mode` equal 2 (wait) one cycle later. This applies even if `req_wfi` is pulsed in the same cycle.
- R2: In run mode, any other `req_wfi` or `req_wfe` pulse makes `mode` equal 1 (sleep) one cycle later. Wake sources, interrupts and events do not move run mode.
- R3: `core_clk_en` is 1 only while `mode` is 0 (run). `pio_hold` is 1 only while `mode` is 2.
- R4: A sleep entered by `req_wfi` returns to run one cycle after `irq_pending` is high, and `evt_pending` has no effect on it. A sleep entered by WFE alone returns to run on `evt_pending`, and `irq_pending` has no effect on it. Sleep ignores the wake sources.
- R5: Wait mode returns to run one cycle after any source is high while its enable is high. A source whose enable is low has no effect. `irq_pending` and `evt_pending` have no effect in wait mode.
- R6: On wait entry, `flash_mode` takes a value from `cfg_flpm`: 0 gives standby (code 1), 1 gives deep power-down (code 2), 2 gives read-idle (code 0), and the reserved value 3 gives standby (code 1).
- R7: After a wake from wait, `flash_mode` keeps its wait value until a `flash_restore` pulse, which sets it to 0 one cycle later. `flash_reconf_pend` is 1 from wait entry until that restore whenever the wait value is not 0. A restore pulse during wait mode has no effect.
- R8: `mclk_sel` follows `sw_mclk_sel` outside wait mode. It keeps the value captured at wait entry for the whole of wait mode and in the first cycle after the wake.
- R9: In run mode, with `cfg_sleep_on_exit`=1, an `exc_return` pulse enters sleep as a WFI sleep. With `cfg_sleep_on_exit`=0 it has no effect.
- R10: `wake_status` bits are sticky. Bits 15:0 are the pins, bit 16 tamper, bit 17 RTC and bit 18 RTT. A bit is set when its enabled source ends a wait. `wake_status_clr` clears the vector, and a bit set in the same cycle as a clear survives.
- R11: After reset: `mode`=0, `core_clk_en`=1, `pio_hold`=0, `mclk_sel`=0, `flash_mode`=0, `flash_reconf_pend`=0 and `wake_status`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wfi | input | 1 | Core wait-for-interrupt request pulse |
| req_wfe | input | 1 | Core wait-for-event request pulse |
| cfg_lpm | input | 1 | Low-power-mode enable |
| cfg_deep_sleep | input | 1 | Core deep-sleep flag |
| cfg_flpm | input | 2 | Flash power state for wait mode |
| cfg_sleep_on_exit | input | 1 | Re-enter sleep on exception return |
| exc_return | input | 1 | Handler returned to thread mode (pulse) |
| irq_pending | input | 1 | Interrupt pending to the core |
| evt_pending | input | 1 | Event pending to the core |
| wk_pin | input | NPINS | Wake pins |
| wk_pin_en | input | NPINS | Per-pin wake enables |
| tamper_evt | input | 1 | Tamper detection |
| tamper_en | input | 1 | Tamper wake enable |
| rtc_alarm | input | 1 | RTC alarm |
| rtc_en | input | 1 | RTC wake enable |
| rtt_alarm | input | 1 | RTT alarm |
| rtt_en | input | 1 | RTT wake enable |
| sw_mclk_sel | input | MCLK_W | Software main clock choice |
| flash_restore | input | 1 | Return flash to read-idle (pulse) |
| wake_status_clr | input | 1 | Clear wake status (pulse) |
| mode | output | 2 | 0 run, 1 sleep, 2 wait |
| core_clk_en | output | 1 | Core clock gate enable |
| pio_hold | output | 1 | Freeze I/O pin configuration |
| mclk_sel | output | MCLK_W | Main clock select |
| flash_mode | output | 2 | 0 read-idle, 1 standby, 2 deep power-down |
| flash_reconf_pend | output | 1 | Flash restore still needed |
| wake_status | output | NPINS+3 | Sticky wake cause |

## Verification
Every output is a flop, so each result is due exactly one clock edge after the inputs that cause it. The bench drives inputs just after a falling edge and samples one falling edge later, which leaves exactly one rising edge in between. The hold properties (R4, R5, R7, R8) are checked in the same way: the stimulus that must be ignored is applied, one edge passes, and the output is read before the next stimulus.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_WAIT  = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    FL_READ = 2'd0,
    FL_STBY = 2'd1,
    FL_DPD  = 2'd2
  } flash_e;

  function automatic flash_e flpm_decode(input logic [1:0] f);
    case (f)
      2'd1:    return FL_DPD;
      2'd2:    return FL_READ;
      default: return FL_STBY;  // 0 and the reserved code
    endcase
  endfunction
endpackage

// File: rtl/pms_wake_mux.sv
module pms_wake_mux #(
  parameter int NPINS = 16,
  localparam int NSRC = NPINS + 3
) (
  input  logic [NPINS-1:0] wk_pin,
  input  logic [NPINS-1:0] wk_pin_en,
  input  logic             tamper_evt,
  input  logic             tamper_en,
  input  logic             rtc_alarm,
  input  logic             rtc_en,
  input  logic             rtt_alarm,
  input  logic             rtt_en,
  output logic [NSRC-1:0]  hit,
  output logic             any_hit
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign hit[i] = wk_pin[i] & wk_pin_en[i];
  end
  assign hit[NPINS]   = tamper_evt & tamper_en;
  assign hit[NPINS+1] = rtc_alarm & rtc_en;
  assign hit[NPINS+2] = rtt_alarm & rtt_en;
  assign any_hit      = |hit;
endmodule

// File: rtl/pms_wake_log.sv
module pms_wake_log #(
  parameter int NSRC = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic [NSRC-1:0] hit,
  input  logic            clr,
  output logic [NSRC-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (clr ? '0 : status) | (capture ? hit : '0);
  end
endmodule

// File: rtl/pms_flash_ctl.sv
module pms_flash_ctl
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enter_wait,
  input  logic       in_wait,
  input  logic [1:0] flpm,
  input  logic       restore,
  output logic [1:0] flash_mode,
  output logic       pend
);
  flash_e fl_q, fl_entry;
  assign fl_entry   = flpm_decode(flpm);
  assign flash_mode = fl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_q <= FL_READ;
      pend <= 1'b0;
    end else if (enter_wait) begin
      fl_q <= fl_entry;
      pend <= (fl_entry != FL_READ);
    end else if (restore && !in_wait) begin
      fl_q <= FL_READ;
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
#(
  parameter int MCLK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wfi,
  input  logic              req_wfe,
  input  logic              cfg_lpm,
  input  logic              cfg_deep_sleep,
  input  logic              cfg_sleep_on_exit,
  input  logic              exc_return,
  input  logic              irq_pending,
  input  logic              evt_pending,
  input  logic              any_wake,
  input  logic [MCLK_W-1:0] sw_mclk_sel,
  output logic [1:0]        mode,
  output logic              core_clk_en,
  output logic              pio_hold,
  output logic [MCLK_W-1:0] mclk_sel,
  output logic              enter_wait,
  output logic              in_wait
);
  mode_e state_q, state_d;
  logic  via_wfe_q, via_wfe_d;

  assign mode    = state_q;
  assign in_wait = (state_q == MODE_WAIT);

  always_comb begin
    state_d    = state_q;
    via_wfe_d  = via_wfe_q;
    enter_wait = 1'b0;
    case (state_q)
      MODE_RUN: begin
        if (req_wfe && cfg_lpm && !cfg_deep_sleep) begin
          state_d    = MODE_WAIT;
          enter_wait = 1'b1;
        end else if (req_wfi || req_wfe) begin
          state_d   = MODE_SLEEP;
          via_wfe_d = !req_wfi;  // WFI takes priority for the wake rule
        end else if (exc_return && cfg_sleep_on_exit) begin
          state_d   = MODE_SLEEP;
          via_wfe_d = 1'b0;
        end
      end
      MODE_SLEEP: if (via_wfe_q ? evt_pending : irq_pending) state_d = MODE_RUN;
      MODE_WAIT:  if (any_wake) state_d = MODE_RUN;
      default:    state_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= MODE_RUN;
      via_wfe_q   <= 1'b0;
      core_clk_en <= 1'b1;
      pio_hold    <= 1'b0;
      mclk_sel    <= '0;
    end else begin
      state_q     <= state_d;
      via_wfe_q   <= via_wfe_d;
      core_clk_en <= (state_d == MODE_RUN);
      pio_hold    <= (state_d == MODE_WAIT);
      if (state_q != MODE_WAIT) mclk_sel <= sw_mclk_sel;
    end
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int NPINS  = 16,
  parameter int MCLK_W = 2,
  localparam int NSRC  = NPINS + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wfi,
  input  logic              req_wfe,
  input  logic              cfg_lpm,
  input  logic              cfg_deep_sleep,
  input  logic [1:0]        cfg_flpm,
  input  logic              cfg_sleep_on_exit,
  input  logic              exc_return,
  input  logic              irq_pending,
  input  logic              evt_pending,
  input  logic [NPINS-1:0]  wk_pin,
  input  logic [NPINS-1:0]  wk_pin_en,
  input  logic              tamper_evt,
  input  logic              tamper_en,
  input  logic              rtc_alarm,
  input  logic              rtc_en,
  input  logic              rtt_alarm,
  input  logic              rtt_en,
  input  logic [MCLK_W-1:0] sw_mclk_sel,
  input  logic              flash_restore,
  input  logic              wake_status_clr,
  output logic [1:0]        mode,
  output logic              core_clk_en,
  output logic              pio_hold,
  output logic [MCLK_W-1:0] mclk_sel,
  output logic [1:0]        flash_mode,
  output logic              flash_reconf_pend,
  output logic [NSRC-1:0]   wake_status
);
  logic [NSRC-1:0] hit;
  logic            any_hit, enter_wait, in_wait;

  pms_wake_mux #(.NPINS(NPINS)) u_mux (
    .wk_pin(wk_pin), .wk_pin_en(wk_pin_en),
    .tamper_evt(tamper_evt), .tamper_en(tamper_en),
    .rtc_alarm(rtc_alarm), .rtc_en(rtc_en),
    .rtt_alarm(rtt_alarm), .rtt_en(rtt_en),
    .hit(hit), .any_hit(any_hit)
  );

  pms_fsm #(.MCLK_W(MCLK_W)) u_fsm (
    .clk(clk), .rst(rst),
    .req_wfi(req_wfi), .req_wfe(req_wfe),
    .cfg_lpm(cfg_lpm), .cfg_deep_sleep(cfg_deep_sleep),
    .cfg_sleep_on_exit(cfg_sleep_on_exit), .exc_return(exc_return),
    .irq_pending(irq_pending), .evt_pending(evt_pending),
    .any_wake(any_hit), .sw_mclk_sel(sw_mclk_sel),
    .mode(mode), .core_clk_en(core_clk_en), .pio_hold(pio_hold),
    .mclk_sel(mclk_sel), .enter_wait(enter_wait), .in_wait(in_wait)
  );

  pms_flash_ctl u_flash (
    .clk(clk), .rst(rst), .enter_wait(enter_wait), .in_wait(in_wait),
    .flpm(cfg_flpm), .restore(flash_restore),
    .flash_mode(flash_mode), .pend(flash_reconf_pend)
  );

  pms_wake_log #(.NSRC(NSRC)) u_log (
    .clk(clk), .rst(rst), .capture(in_wait), .hit(hit),
    .clr(wake_status_clr), .status(wake_status)
  );
endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
  parameter int NPINS  = 16,
  parameter int MCLK_W = 2,
  localparam int NSRC  = NPINS + 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_wfi,
  input logic              req_wfe,
  input logic              cfg_lpm,
  input logic              cfg_deep_sleep,
  input logic [1:0]        cfg_flpm,
  input logic              cfg_sleep_on_exit,
  input logic              exc_return,
  input logic              irq_pending,
  input logic              evt_pending,
  input logic [NPINS-1:0]  wk_pin,
  input logic [NPINS-1:0]  wk_pin_en,
  input logic              tamper_evt,
  input logic              tamper_en,
  input logic              rtc_alarm,
  input logic              rtc_en,
  input logic              rtt_alarm,
  input logic              rtt_en,
  input logic [MCLK_W-1:0] sw_mclk_sel,
  input logic              flash_restore,
  input logic              wake_status_clr,
  input logic [1:0]        mode,
  input logic              core_clk_en,
  input logic              pio_hold,
  input logic [MCLK_W-1:0] mclk_sel,
  input logic [1:0]        flash_mode,
  input logic              flash_reconf_pend,
  input logic [NSRC-1:0]   wake_status
);
  logic src_on;
  assign src_on = (|(wk_pin & wk_pin_en)) | (tamper_evt & tamper_en)
                | (rtc_alarm & rtc_en) | (rtt_alarm & rtt_en);

  a_r1_wait_entry: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && req_wfe && cfg_lpm && !cfg_deep_sleep) |=> (mode == 2'd2));

  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && req_wfi && !(req_wfe && cfg_lpm && !cfg_deep_sleep)) |=> (mode == 2'd1));

  a_r3_clk_gate: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd0) |-> !core_clk_en);

  a_r3_pio_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2) |-> pio_hold);

  a_r4_sleep_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && !irq_pending && !evt_pending) |=> (mode == 2'd1));

  a_r5_wait_exit: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && src_on) |=> (mode == 2'd0));

  a_r7_restore_ignored: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && flash_restore) |=> $stable(flash_mode));

  a_r8_mclk_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2) |=> $stable(mclk_sel));

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    !wake_status_clr |=> ((wake_status & $past(wake_status)) == $past(wake_status)));
endmodule

bind pwr_mode_seq pms_checker #(.NPINS(NPINS), .MCLK_W(MCLK_W)) chk_i (.*);

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb_top;
  localparam int NPINS = 16;
  localparam int NSRC  = NPINS + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_wfi = 0, req_wfe = 0, cfg_lpm = 0, cfg_deep_sleep = 0;
  logic [1:0] cfg_flpm = 0;
  logic cfg_sleep_on_exit = 0, exc_return = 0, irq_pending = 0, evt_pending = 0;
  logic [NPINS-1:0] wk_pin = '0, wk_pin_en = '0;
  logic tamper_evt = 0, tamper_en = 0, rtc_alarm = 0, rtc_en = 0, rtt_alarm = 0, rtt_en = 0;
  logic [1:0] sw_mclk_sel = 0;
  logic flash_restore = 0, wake_status_clr = 0;
  logic [1:0] mode, mclk_sel, flash_mode;
  logic core_clk_en, pio_hold, flash_reconf_pend;
  logic [NSRC-1:0] wake_status;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_mode_seq dut_i (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fl_exp(int f);
    return (f == 1) ? 2 : (f == 2) ? 0 : 1;
  endfunction

  task automatic set_src(int s, bit v, bit en);
    if (s < NPINS) begin wk_pin[s] = v; wk_pin_en[s] = en; end
    else if (s == NPINS)     begin tamper_evt = v; tamper_en = en; end
    else if (s == NPINS + 1) begin rtc_alarm = v;  rtc_en = en;    end
    else                     begin rtt_alarm = v;  rtt_en = en;    end
  endtask

  task automatic go_wait(int f);
    cfg_lpm = 1; cfg_deep_sleep = 0; cfg_flpm = 2'(f);
    req_wfe = 1; tick(); req_wfe = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst = 0; tick();
    // R11 reset state
    chk("R11 mode", mode, 0); chk("R11 clk", core_clk_en, 1); chk("R11 pio", pio_hold, 0);
    chk("R11 mclk", mclk_sel, 0); chk("R11 flash", flash_mode, 0);
    chk("R11 pend", flash_reconf_pend, 0); chk("R11 status", wake_status, 0);

    // R2: wake sources, irq and events do not move run mode
    irq_pending = 1; evt_pending = 1; set_src(3, 1, 1); tick();
    chk("R2 run hold", mode, 0);
    irq_pending = 0; evt_pending = 0; set_src(3, 0, 0);

    // Sweep over instruction, lpm, deep-sleep and flash field
    for (int w = 0; w < 2; w++)
      for (int l = 0; l < 2; l++)
        for (int d = 0; d < 2; d++)
          for (int f = 0; f < 4; f++) begin
            bit to_wait;
            to_wait = (w == 1) && (l == 1) && (d == 0);
            cfg_lpm = l[0]; cfg_deep_sleep = d[0]; cfg_flpm = 2'(f);
            if (w == 1) req_wfe = 1; else req_wfi = 1;
            tick(); req_wfe = 0; req_wfi = 0;
            chk(to_wait ? "R1 mode" : "R2 mode", mode, to_wait ? 2 : 1);
            chk("R3 clk", core_clk_en, 0);
            chk("R3 pio", pio_hold, to_wait ? 1 : 0);
            if (to_wait) begin
              chk("R6 flash", flash_mode, fl_exp(f));
              chk("R7 pend", flash_reconf_pend, (fl_exp(f) != 0) ? 1 : 0);
              irq_pending = 1; evt_pending = 1; set_src(f, 1, 0); tick();
              chk("R5 ignore", mode, 2);
              irq_pending = 0; evt_pending = 0; set_src(f, 1, 1); tick();
              set_src(f, 0, 0);
              chk("R5 exit", mode, 0);
              chk("R7 flash kept", flash_mode, fl_exp(f));
              flash_restore = 1; wake_status_clr = 1; tick();
              flash_restore = 0; wake_status_clr = 0;
              chk("R7 restore", flash_mode, 0); chk("R7 pend clr", flash_reconf_pend, 0);
            end else begin
              set_src(0, 1, 1);
              if (w == 1) irq_pending = 1; else evt_pending = 1;
              tick();
              chk("R4 wrong wake", mode, 1);
              set_src(0, 0, 0); irq_pending = 0; evt_pending = 0;
              if (w == 1) evt_pending = 1; else irq_pending = 1;
              tick(); irq_pending = 0; evt_pending = 0;
              chk("R4 wake", mode, 0); chk("R3 clk run", core_clk_en, 1);
            end
          end

    // R1: wfi together with wfe still goes to wait
    cfg_lpm = 1; cfg_deep_sleep = 0; req_wfi = 1; req_wfe = 1; tick();
    req_wfi = 0; req_wfe = 0;
    chk("R1 both", mode, 2);
    set_src(NPINS, 1, 1); tick(); set_src(NPINS, 0, 0);
    chk("R10 tamper", wake_status, 1 << NPINS);

    // R10 / R5: every wake source, disabled then enabled
    for (int s = 0; s < NSRC; s++) begin
      wake_status_clr = 1; tick(); wake_status_clr = 0;
      chk("R10 clear", wake_status, 0);
      go_wait(2);
      set_src(s, 1, 0); tick();
      chk("R5 disabled", mode, 2);
      set_src(s, 1, 1); tick(); set_src(s, 0, 0);
      chk("R5 enabled", mode, 0);
      chk("R10 cause", wake_status, 1 << s);
    end

    // R10: set wins over clear
    go_wait(2);
    set_src(5, 1, 1); wake_status_clr = 1; tick();
    set_src(5, 0, 0); wake_status_clr = 0;
    chk("R10 set wins", wake_status, 1 << 5);

    // R7: restore ignored in wait
    go_wait(1);
    flash_restore = 1; tick(); flash_restore = 0;
    chk("R7 ignore", flash_mode, 2);
    set_src(17, 1, 1); tick(); set_src(17, 0, 0);
    chk("R7 pend", flash_reconf_pend, 1);
    flash_restore = 1; tick(); flash_restore = 0;
    chk("R7 read", flash_mode, 0);

    // R8: clock select held through wait
    sw_mclk_sel = 2; tick(); chk("R8 follow", mclk_sel, 2);
    go_wait(0);
    sw_mclk_sel = 1; tick(); chk("R8 hold", mclk_sel, 2);
    set_src(18, 1, 1); tick(); set_src(18, 0, 0);
    chk("R8 exit", mclk_sel, 2);
    tick(); chk("R8 resume", mclk_sel, 1);

    // R9: sleep on exit
    cfg_sleep_on_exit = 0; exc_return = 1; tick(); exc_return = 0;
    chk("R9 off", mode, 0);
    cfg_sleep_on_exit = 1; exc_return = 1; tick(); exc_return = 0;
    chk("R9 on", mode, 1);
    evt_pending = 1; tick(); evt_pending = 0;
    chk("R9 wfi kind", mode, 1);
    irq_pending = 1; tick(); irq_pending = 0;
    chk("R9 wake", mode, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule